// File: doc/BRIEF.md
# Truncated Carry-Save Hit Counter

This block counts how many outputs of a 16 by 16 detector matrix are set in one sample. A strobe marks each sample, and a new sample may arrive on every clock cycle. Each row of hits is reduced by a carry-save tree of full adders. The row totals are registered, and a second carry-save tree then combines them. The total leaves the block three clock edges after the strobe, paired with a one-cycle valid pulse.

Few events are expected per sample, so the default build keeps only the three low-order bits in every adder stage. A carry that would leave the top kept bit is not summed. Instead it sets an overflow flag. The overflow flag is therefore exact: it is high if and only if the sample held eight or more hits. A parameter selects the full-width build, which yields the complete 9-bit total, so the two builds can be set side by side and compared.

Top module: `trunc_hit_counter`

## Requirements
- R1: When sample_i is high at a rising edge, hits_i is taken in at that edge. Its result drives count_o and ovf_o, with valid_o high, exactly three rising edges later.
- R2: valid_o is high only in cycles that answer a strobe. While sample_i is low, hits_i is ignored, and count_o and ovf_o keep the last result.
- R3: Pruned build (FULL=0, 3-bit count_o). For a sample with 0 to 7 set bits, count_o equals the number of set bits and ovf_o is low.
- R4: Pruned build. For a sample with 8 or more set bits, ovf_o is high and count_o equals that number modulo 8. This includes samples whose hits all sit in one row of 8 or more.
- R5: Full build (FULL=1, 9-bit count_o). count_o equals the number of set bits, from 0 to 256, and ovf_o is always low.
- R6: For any sample with 7 or fewer set bits, the pruned and full builds give the same count.
- R7: Strobes on consecutive cycles give results on consecutive cycles, with no sample lost.
- R8: Driving rst_ni low clears count_o, ovf_o and valid_o at once, without waiting for a clock edge. Samples still in the pipeline are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Strobe that accepts hits_i this cycle |
| hits_i | input | 256 | Detector outputs; bit r*16+c is row r, column c |
| count_o | output | 3 (9 when FULL=1) | Number of hits in the sample |
| ovf_o | output | 1 | Sample held more hits than count_o can show |
| valid_o | output | 1 | count_o and ovf_o belong to a new sample |

## Verification
The assertions assume that sample_i is a clean, clock-synchronous level that does not toggle while rst_ni is low. The latency and hold properties relate the strobe to valid_o on that basis. The stimulus drives every input at the falling edge and keeps sample_i low throughout reset. It weights the random hit counts toward 0 to 7, with a tail up to 20, and adds directed samples: all hits in one row, a full matrix, and bursts of back-to-back strobes. While the strobe is low, hits_i carries random values, so the hold rule is tested against noise rather than quiet inputs.

// File: rtl/trunc_hit_pkg.sv
package trunc_hit_pkg;

  // operand count after one 3:2 compression level
  function automatic int csa_step(input int n);
    return (n < 3) ? n : 2 * (n / 3) + (n % 3);
  endfunction

  function automatic int csa_count(input int n, input int lvls);
    int m = n;
    for (int i = 0; i < lvls; i++) m = csa_step(m);
    return m;
  endfunction

  function automatic int csa_depth(input int n);
    int m = n;
    int d = 0;
    while (m > 2) begin
      m = csa_step(m);
      d++;
    end
    return d;
  endfunction

  function automatic int cnt_width(input bit full, input int rows, input int cols,
                                   input int trunc_w);
    return full ? $clog2(rows * cols + 1) : trunc_w;
  endfunction

endpackage

// File: rtl/hit_csa3.sv
// Word-wide 3:2 compressor; carry out of the MSB is reported, not kept.
module hit_csa3 #(
  parameter int W = 3
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o,
  output logic         drop_o
);
  logic [W-1:0] maj;

  assign s_o    = a_i ^ b_i ^ c_i;
  assign maj    = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  assign c_o    = {maj[W-2:0], 1'b0};
  assign drop_o = maj[W-1];
endmodule

// File: rtl/hit_csa_tree.sv
module hit_csa_tree
  import trunc_hit_pkg::*;
#(
  parameter int N = 16,
  parameter int W = 3
) (
  input  logic [N-1:0][W-1:0] ops_i,
  output logic [W-1:0]        sum_o,
  output logic                drop_o
);
  localparam int LV = csa_depth(N);
  localparam int NF = csa_count(N, LV);

  logic [W-1:0] lv [LV+1][N];
  logic [LV:0]  drop_lvl;
  logic [W-1:0] op_b;
  logic [W:0]   fin;

  for (genvar i = 0; i < N; i++) begin : g_in
    assign lv[0][i] = ops_i[i];
  end

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    localparam int NI = csa_count(N, l);
    localparam int NG = NI / 3;
    localparam int NR = NI % 3;
    localparam int NO = 2 * NG + NR;
    logic [NG-1:0] gd;

    for (genvar g = 0; g < NG; g++) begin : g_fa
      hit_csa3 #(.W(W)) u_fa (
        .a_i   (lv[l][3*g]),
        .b_i   (lv[l][3*g+1]),
        .c_i   (lv[l][3*g+2]),
        .s_o   (lv[l+1][g]),
        .c_o   (lv[l+1][NG+g]),
        .drop_o(gd[g])
      );
    end
    for (genvar r = 0; r < NR; r++) begin : g_pass
      assign lv[l+1][2*NG+r] = lv[l][3*NG+r];
    end
    for (genvar k = NO; k < N; k++) begin : g_zero
      assign lv[l+1][k] = '0;
    end
    assign drop_lvl[l] = |gd;
  end

  if (NF > 1) begin : g_two
    assign op_b = lv[LV][1];
  end else begin : g_one
    assign op_b = '0;
  end

  assign fin          = {1'b0, lv[LV][0]} + {1'b0, op_b};
  assign sum_o        = fin[W-1:0];
  assign drop_lvl[LV] = fin[W];
  assign drop_o       = |drop_lvl;
endmodule

// File: rtl/trunc_hit_counter.sv
module trunc_hit_counter
  import trunc_hit_pkg::*;
#(
  parameter int ROWS    = 16,
  parameter int COLS    = 16,
  parameter bit FULL    = 1'b0,
  parameter int TRUNC_W = 3
) (
  input  logic                                           clk_i,
  input  logic                                           rst_ni,
  input  logic                                           sample_i,
  input  logic [ROWS*COLS-1:0]                           hits_i,
  output logic [cnt_width(FULL, ROWS, COLS, TRUNC_W)-1:0] count_o,
  output logic                                           ovf_o,
  output logic                                           valid_o
);
  localparam int N_HITS     = ROWS * COLS;
  localparam int CNT_W      = cnt_width(FULL, ROWS, COLS, TRUNC_W);
  localparam int ROW_FULL_W = $clog2(COLS + 1);
  localparam int ROW_W      = (ROW_FULL_W < CNT_W) ? ROW_FULL_W : CNT_W;

  logic [N_HITS-1:0]            hits_q;
  logic                         v1_q, v2_q;
  logic [ROWS-1:0][ROW_W-1:0]   row_sum_d, row_sum_q;
  logic [ROWS-1:0]              row_drop_d, row_drop_q;
  logic [ROWS-1:0][CNT_W-1:0]   col_ops;
  logic [CNT_W-1:0]             col_sum;
  logic                         col_drop;

  // stage 1: capture sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hits_q <= '0;
      v1_q   <= 1'b0;
    end else begin
      v1_q <= sample_i;
      if (sample_i) hits_q <= hits_i;
    end
  end

  // stage 2: per-row reduction
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [COLS-1:0][ROW_W-1:0] rops;
    for (genvar c = 0; c < COLS; c++) begin : g_bit
      assign rops[c] = ROW_W'(hits_q[r*COLS+c]);
    end
    hit_csa_tree #(.N(COLS), .W(ROW_W)) u_row (
      .ops_i (rops),
      .sum_o (row_sum_d[r]),
      .drop_o(row_drop_d[r])
    );
    assign col_ops[r] = CNT_W'(row_sum_q[r]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_sum_q  <= '0;
      row_drop_q <= '0;
      v2_q       <= 1'b0;
    end else begin
      v2_q <= v1_q;
      if (v1_q) begin
        row_sum_q  <= row_sum_d;
        row_drop_q <= row_drop_d;
      end
    end
  end

  // stage 3: combine rows
  hit_csa_tree #(.N(ROWS), .W(CNT_W)) u_col (
    .ops_i (col_ops),
    .sum_o (col_sum),
    .drop_o(col_drop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      ovf_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= v2_q;
      if (v2_q) begin
        count_o <= col_sum;
        ovf_o   <= col_drop | (|row_drop_q);
      end
    end
  end
endmodule

// File: rtl/trunc_hit_counter_sva.sv
module trunc_hit_counter_sva #(
  parameter bit FULL  = 1'b0,
  parameter int CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sample_i,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_o,
  input logic             valid_o
);
  p_valid_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |-> ##3 valid_o);

  p_valid_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(sample_i, 3));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(count_o) && $stable(ovf_o)));

  p_ovf_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> valid_o);

  if (FULL) begin : g_full
    p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ovf_o);
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_rst_clear_r8: assert (!valid_o && !ovf_o && count_o == '0);
    end
  end
endmodule

bind trunc_hit_counter trunc_hit_counter_sva #(.FULL(FULL), .CNT_W(CNT_W)) u_sva (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sample_i(sample_i),
  .count_o (count_o),
  .ovf_o   (ovf_o),
  .valid_o (valid_o)
);

// File: tb/trunc_hit_counter_test.sv
module trunc_hit_counter_test;
  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         sample_i;
  logic [255:0] hits_i;
  logic [2:0]   cnt_p;
  logic         ovf_p, val_p;
  logic [8:0]   cnt_f;
  logic         ovf_f, val_f;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [255:0] hh [3];
  logic         hv [3];
  logic [2:0]   held_p;
  logic         held_ovf;
  logic [8:0]   held_f;
  logic         prev_v;

  always #10 clk_i = ~clk_i;

  trunc_hit_counter #(.FULL(1'b0)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .hits_i(hits_i),
    .count_o(cnt_p), .ovf_o(ovf_p), .valid_o(val_p));

  trunc_hit_counter #(.FULL(1'b1)) uut_full (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .hits_i(hits_i),
    .count_o(cnt_f), .ovf_o(ovf_f), .valid_o(val_f));

  function automatic int popcnt(input logic [255:0] v);
    int n = 0;
    for (int i = 0; i < 256; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic [255:0] rand_hits(input int k);
    logic [255:0] v = '0;
    for (int i = 0; i < k; i++) v[$urandom_range(255, 0)] = 1'b1;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 3; i++) begin
      hh[i] = '0;
      hv[i] = 1'b0;
    end
    held_p = '0; held_ovf = 1'b0; held_f = '0; prev_v = 1'b0;
  endtask

  // one cycle: check outputs for the sample driven three negedges ago, then drive
  task automatic cycle(input logic s, input logic [255:0] v);
    int n;
    @(negedge clk_i);
    chk(val_p == hv[2], "R1 valid pruned", int'(val_p), int'(hv[2]));
    chk(val_f == hv[2], "R1 valid full", int'(val_f), int'(hv[2]));
    if (hv[2]) begin
      n = popcnt(hh[2]);
      if (prev_v) chk(val_p && val_f, "R7 back-to-back", int'(val_p), 1);
      if (n <= 7) begin
        chk(cnt_p == 3'(n), "R3 count", int'(cnt_p), n);
        chk(!ovf_p, "R3 ovf", int'(ovf_p), 0);
        chk(cnt_p == cnt_f[2:0] && cnt_f[8:3] == '0, "R6 agree", int'(cnt_p), int'(cnt_f));
      end else begin
        chk(ovf_p, "R4 ovf", int'(ovf_p), 1);
        chk(cnt_p == 3'(n % 8), "R4 count mod 8", int'(cnt_p), n % 8);
      end
      chk(cnt_f == 9'(n), "R5 count", int'(cnt_f), n);
      chk(!ovf_f, "R5 ovf", int'(ovf_f), 0);
      held_p = 3'(n % 8); held_ovf = (n > 7); held_f = 9'(n);
    end else begin
      chk(cnt_p == held_p && ovf_p == held_ovf, "R2 hold pruned", int'(cnt_p), int'(held_p));
      chk(cnt_f == held_f, "R2 hold full", int'(cnt_f), int'(held_f));
    end
    prev_v = hv[2];
    hh[2] = hh[1]; hv[2] = hv[1];
    hh[1] = hh[0]; hv[1] = hv[0];
    sample_i = s; hits_i = v;
    hh[0] = v; hv[0] = s;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [255:0] v;
    void'($urandom(32'd1234));
    rst_ni = 1'b1; sample_i = 1'b0; hits_i = '0;
    clear_hist();
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    // R8 reset state
    chk(cnt_p == '0 && !ovf_p && !val_p, "R8 reset pruned", int'(cnt_p), 0);
    chk(cnt_f == '0 && !ovf_f && !val_f, "R8 reset full", int'(cnt_f), 0);
    rst_ni = 1'b1;

    // directed corners
    cycle(1'b1, '0);
    cycle(1'b1, 256'h7f);                          // 7 in row 0
    cycle(1'b1, 256'hff);                          // 8 in row 0: row-level overflow
    v = '0;
    for (int r = 0; r < 8; r++) v[r*16+3] = 1'b1;  // 8 spread over rows
    cycle(1'b1, v);
    cycle(1'b1, 256'hffff);                        // full row
    cycle(1'b1, '1);                               // all 256
    cycle(1'b1, 256'h1);
    // strobe low with noise on hits: ignored (R2)
    for (int i = 0; i < 6; i++) cycle(1'b0, rand_hits(40));
    // R7 burst of consecutive strobes
    for (int i = 0; i < 8; i++) cycle(1'b1, rand_hits(i));

    // constrained random
    for (int i = 0; i < 600; i++) begin
      int sel = $urandom_range(9, 0);
      int k;
      if (sel < 6)      k = $urandom_range(4, 0);
      else if (sel < 8) k = $urandom_range(7, 5);
      else              k = $urandom_range(20, 8);
      cycle($urandom_range(3, 0) != 0, rand_hits(k));
    end

    // R8 reset mid-flight
    cycle(1'b1, rand_hits(9));
    cycle(1'b1, rand_hits(3));
    #3 rst_ni = 1'b0;
    #2;
    chk(cnt_p == '0 && !ovf_p && !val_p, "R8 async clear pruned", int'(cnt_p), 0);
    chk(cnt_f == '0 && !val_f, "R8 async clear full", int'(cnt_f), 0);
    sample_i = 1'b0;
    clear_hist();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) cycle(1'b0, '0);   // dropped samples never appear
    cycle(1'b1, 256'h3);
    for (int i = 0; i < 4; i++) cycle(1'b0, '0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule